// File: doc/BRIEF.md
# Thermal Trip Threshold Unit with Averaged Soft Limit

This block decides when thermal control should engage. It keeps a 32-bit control word that holds three fields. One is a fixed maximum junction temperature, set at build time and read-only to software. One is a programmable offset in degrees Celsius. One is an averaging window. Digital temperature samples arrive on a valid/ready stream. On each sample the block updates two registered flags.

The hard trip is raised whenever a sample reaches the fixed maximum. No field setting can mask it. The soft trip uses a lower set point: the maximum minus the offset, clamped at zero. With a window of zero, the soft trip compares the raw sample against that set point. With any other window, it compares an exponentially weighted moving average of the samples. The instantaneous temperature can then pass the set point for a while before the soft trip fires.

The sample stream never applies back-pressure. `smp_ready` is low while reset is held and goes high on the first clock edge after reset is released. It then stays high, so a sample counts as accepted in every cycle where `smp_valid` and `smp_ready` are both high. A cycle with `smp_valid` low has no effect on the average or on either flag.

Top module: `thermal_trip_unit`

## Requirements
- R1: After reset the offset and window fields read as zero, both trip flags are low, and `smp_ready` is low during reset and high from the first clock edge after reset is released.
- R2: `ctl_rdata` returns the control word: offset in bits [29:24], fixed maximum in bits [23:16], window in bits [6:0], and zero in all other bits. A write with `ctl_we` high loads offset from `ctl_wdata[29:24]` and window from `ctl_wdata[6:0]`, visible on the next cycle.
- R3: The maximum field is read-only. Bits [23:16] of a write are ignored, so both the readback and the hard-trip threshold keep the value of parameter `TJ_LIMIT`.
- R4: One cycle after an accepted sample, `trip_hard` is 1 exactly when the sample is greater than or equal to the fixed maximum, whatever the offset and window.
- R5: The soft set point is the fixed maximum minus the offset, or zero if the offset is larger than the maximum.
- R6: With window zero, one cycle after an accepted sample `trip_soft` is 1 exactly when the sample is greater than or equal to the set point.
- R7: With a nonzero window, the average (8 fraction bits) is updated on each accepted sample as avg += (sample - avg) >>> k. Here k is the bit length of the window field (1 gives 1, 2 to 3 give 2, 4 to 7 give 3, and so on), capped at 8. The first accepted sample after reset loads the average directly.
- R8: While the window is zero, the average follows each accepted sample exactly, so enabling averaging starts from the most recent sample.
- R9: With a nonzero window, `trip_soft` one cycle after an accepted sample is 1 exactly when the integer part of the updated average is greater than or equal to the set point. A sample above the set point therefore does not by itself raise the soft trip.
- R10: Both trip flags change only on the clock edge that accepts a sample. In every other cycle they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| smp_valid | input | 1 | Temperature sample valid |
| smp_ready | output | 1 | Sample stream ready (never stalls after reset) |
| smp_temp | input | 8 | Temperature sample in degrees Celsius |
| trip_hard | output | 1 | Sample reached the fixed maximum |
| trip_soft | output | 1 | Raw or averaged temperature reached the offset set point |

## Verification
The hardest situation to reach is a soft trip driven by the average, where the raw sample has already passed the set point but the filtered value has not. A second hard case is the step from raw mode into averaging, which depends on what the average held before the window was opened. The directed tests reach both by resetting and then feeding short sample runs with hand-computed fixed-point averages. These runs show a sample above the set point that leaves the soft flag low, followed by the sample that raises it. Another test writes window zero, sends one sample, and then opens the window, so the next average is checked against that last raw sample.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;

  localparam int TEMP_W   = 8;
  localparam int OFS_W    = 6;
  localparam int WIN_W    = 7;
  localparam int CTL_W    = 32;

  // Field positions of the control word
  localparam int OFS_LSB  = 24;
  localparam int TJ_LSB   = 16;
  localparam int WIN_LSB  = 0;

  typedef struct packed {
    logic [OFS_W-1:0] offset;
    logic [WIN_W-1:0] window;
  } thermal_ctl_t;

  // Bit length of a window value, capped
  function automatic int win_to_shift(input logic [WIN_W-1:0] w, input int cap);
    int k;
    k = 0;
    for (int i = 0; i < WIN_W; i++) begin
      if (w[i]) k = i + 1;
    end
    if (k > cap) k = cap;
    return k;
  endfunction

endpackage

// File: rtl/thermal_ctl_reg.sv
module thermal_ctl_reg
  import thermal_trip_pkg::*;
#(
  parameter int TJ_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output thermal_ctl_t     ctl,
  output logic [CTL_W-1:0] rd_data
);

  localparam logic [TEMP_W-1:0] TJ_VAL = TEMP_W'(TJ_LIMIT);

  thermal_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q.offset <= wr_data[OFS_LSB +: OFS_W];
      ctl_q.window <= wr_data[WIN_LSB +: WIN_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[OFS_LSB +: OFS_W]  = ctl_q.offset;
    rd_data[TJ_LSB  +: TEMP_W] = TJ_VAL;
    rd_data[WIN_LSB +: WIN_W]  = ctl_q.window;
  end

  assign ctl = ctl_q;

  // R2: a write is reflected in the stored fields on the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q.offset == $past(wr_data[OFS_LSB +: OFS_W])) &&
              (ctl_q.window == $past(wr_data[WIN_LSB +: WIN_W])));

endmodule

// File: rtl/thermal_ewma.sv
module thermal_ewma
  import thermal_trip_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [TEMP_W-1:0] sample,
  input  logic [WIN_W-1:0]  window,
  output logic [TEMP_W-1:0] avg_next_int
);

  localparam int AVG_W = TEMP_W + FRAC_W;

  logic [AVG_W-1:0]  avg_q;
  logic [AVG_W-1:0]  avg_next;
  logic              seeded_q;
  logic [AVG_W-1:0]  sample_fx;
  logic signed [AVG_W:0] diff;
  logic signed [AVG_W:0] step;
  int                shift_k;

  assign sample_fx = {sample, {FRAC_W{1'b0}}};
  assign shift_k   = win_to_shift(window, FRAC_W);
  assign diff      = $signed({1'b0, sample_fx}) - $signed({1'b0, avg_q});
  assign step      = diff >>> shift_k;

  always_comb begin
    if (!seeded_q || window == '0) begin
      avg_next = sample_fx;
    end else begin
      avg_next = avg_q + step[AVG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avg_q    <= '0;
      seeded_q <= 1'b0;
    end else if (accept) begin
      avg_q    <= avg_next;
      seeded_q <= 1'b1;
    end
  end

  assign avg_next_int = avg_next[AVG_W-1:FRAC_W];

  // R7: an averaging update moves the stored value toward the sample, never past it
  p_avg_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seeded_q && window != '0) |=>
      (($past(sample_fx) >= $past(avg_q)) ?
         (avg_q >= $past(avg_q) && avg_q <= $past(sample_fx)) :
         (avg_q <= $past(avg_q) && avg_q >= $past(sample_fx))));

  // R8: in raw mode the stored average equals the accepted sample
  p_track_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && window == '0) |=> (avg_q == $past(sample_fx)));

endmodule

// File: rtl/thermal_compare.sv
module thermal_compare
  import thermal_trip_pkg::*;
#(
  parameter int TJ_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] avg_int,
  input  logic [WIN_W-1:0]  window,
  input  logic [OFS_W-1:0]  offset,
  output logic              hard_q,
  output logic              soft_q
);

  localparam logic [TEMP_W-1:0] TJ_VAL = TEMP_W'(TJ_LIMIT);

  logic [TEMP_W-1:0] setpoint;
  logic [TEMP_W-1:0] soft_val;
  logic [TEMP_W-1:0] ofs_ext;

  assign ofs_ext  = TEMP_W'(offset);
  assign setpoint = (ofs_ext > TJ_VAL) ? '0 : (TJ_VAL - ofs_ext);
  assign soft_val = (window == '0) ? sample : avg_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
    end else if (accept) begin
      hard_q <= (sample >= TJ_VAL);
      soft_q <= (soft_val >= setpoint);
    end
  end

  // R5: the soft set point never exceeds the fixed maximum
  p_setpoint_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    setpoint <= TJ_VAL);

  // R4: a sample at or above the maximum raises the hard trip next cycle
  p_hard_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sample >= TJ_VAL) |=> hard_q);

  // R6: in raw mode a sample at or above the set point raises the soft trip
  p_soft_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && window == '0 && sample >= setpoint) |=> soft_q);

  // R10: without an accepted sample both flags hold
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(hard_q) && $stable(soft_q)));

endmodule

// File: rtl/thermal_trip_unit.sv
module thermal_trip_unit
  import thermal_trip_pkg::*;
#(
  parameter int TJ_LIMIT = 100,
  parameter int FRAC_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [7:0]  smp_temp,
  output logic        trip_hard,
  output logic        trip_soft
);

  thermal_ctl_t      ctl;
  logic              ready_q;
  logic              accept;
  logic [TEMP_W-1:0] avg_int;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign smp_ready = ready_q;
  assign accept    = smp_valid && ready_q;

  thermal_ctl_reg #(.TJ_LIMIT(TJ_LIMIT)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .ctl     (ctl),
    .rd_data (ctl_rdata)
  );

  thermal_ewma #(.FRAC_W(FRAC_W)) u_ewma (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .sample       (smp_temp),
    .window       (ctl.window),
    .avg_next_int (avg_int)
  );

  thermal_compare #(.TJ_LIMIT(TJ_LIMIT)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .sample  (smp_temp),
    .avg_int (avg_int),
    .window  (ctl.window),
    .offset  (ctl.offset),
    .hard_q  (trip_hard),
    .soft_q  (trip_soft)
  );

  // R3: the maximum field of the readback never changes
  p_tj_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[23:16] == $past(ctl_rdata[23:16])));

endmodule

// File: tb/thermal_trip_unit_tb_top.sv
module thermal_trip_unit_tb_top;

  localparam int TJ = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  smp_temp = '0;
  logic        trip_hard;
  logic        trip_soft;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  thermal_trip_unit #(.TJ_LIMIT(TJ)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_temp(smp_temp), .trip_hard(trip_hard), .trip_soft(trip_soft)
  );

  // Raw-mode vectors: {offset[7:0], temp[7:0], exp_hard, exp_soft}; set point = 60 - offset
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {8'd0,  8'd59,  1'b0, 1'b0},
    {8'd0,  8'd60,  1'b1, 1'b1},
    {8'd5,  8'd55,  1'b0, 1'b1},
    {8'd5,  8'd54,  1'b0, 1'b0},
    {8'd20, 8'd40,  1'b0, 1'b1},
    {8'd20, 8'd39,  1'b0, 1'b0},
    {8'd63, 8'd0,   1'b0, 1'b1},
    {8'd0,  8'd63,  1'b1, 1'b1},
    {8'd30, 8'd255, 1'b1, 1'b1},
    {8'd12, 8'd47,  1'b0, 1'b0},
    {8'd12, 8'd48,  1'b0, 1'b1},
    {8'd60, 8'd0,   1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    ctl_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input int ofs, input int win, input int tjf);
    @(negedge clk);
    ctl_wdata = '0;
    ctl_wdata[29:24] = 6'(ofs);
    ctl_wdata[23:16] = 8'(tjf);
    ctl_wdata[6:0]   = 7'(win);
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic send(input int t);
    @(negedge clk);
    smp_temp = 8'(t);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic chk_trip(input string req, input logic eh, input logic es);
    chk(req, {30'd0, trip_hard, trip_soft}, {30'd0, eh, es});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", {31'd0, smp_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, smp_ready}, 32'd1);
    chk_trip("R1 trips after reset", 1'b0, 1'b0);
    // R2: readback layout with reset fields
    chk("R2 reset readback", ctl_rdata, 32'h003C_0000);

    // R2/R3: write all fields, maximum ignored
    wr_ctl(45, 99, 8'hFF);
    chk("R2 R3 readback after write", ctl_rdata, {2'b00, 6'd45, 8'd60, 9'd0, 7'd99});

    // Table walk, raw mode (R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      wr_ctl(int'(VEC[i][17:10]), 0, 0);
      send(int'(VEC[i][9:2]));
      chk_trip($sformatf("R4 R5 R6 vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R3: hard threshold unaffected by writing the maximum field
    wr_ctl(0, 0, 8'd20);
    send(59);
    chk_trip("R3 hard below fixed max", 1'b0, 1'b0);
    send(60);
    chk_trip("R3 hard at fixed max", 1'b1, 1'b1);

    // R10: idle cycle with valid low leaves flags alone
    @(negedge clk);
    smp_temp = 8'd0;
    @(negedge clk);
    chk_trip("R10 hold without valid", 1'b1, 1'b1);

    // R7 R9: window 1 (k=1), set point 50
    do_reset();
    wr_ctl(10, 1, 0);
    send(40);
    chk_trip("R7 seed 40", 1'b0, 1'b0);
    send(56);
    chk_trip("R9 avg 48 sample 56 no soft", 1'b0, 1'b0);
    send(56);
    chk_trip("R9 avg 52 soft", 1'b0, 1'b1);
    send(20);
    chk_trip("R9 avg 36 soft clears", 1'b0, 1'b0);
    send(60);
    chk_trip("R4 hard with averaging avg 48", 1'b1, 1'b0);

    // R7: window 3 (k=2), set point 50
    do_reset();
    wr_ctl(10, 3, 0);
    send(40);
    chk_trip("R7 k2 seed", 1'b0, 1'b0);
    send(60);
    chk_trip("R7 k2 avg 45", 1'b1, 1'b0);
    send(60);
    chk_trip("R7 k2 avg 48.75", 1'b1, 1'b0);
    send(60);
    chk_trip("R7 k2 avg 51.56", 1'b1, 1'b1);

    // R8: raw mode then averaging starts from last sample
    do_reset();
    wr_ctl(10, 0, 0);
    send(59);
    send(30);
    chk_trip("R8 raw 30", 1'b0, 1'b0);
    wr_ctl(10, 1, 0);
    send(60);
    chk_trip("R8 avg 45 from last raw", 1'b1, 1'b0);
    send(60);
    chk_trip("R8 avg 52.5", 1'b1, 1'b1);

    // R10: averaging not advanced by idle cycles
    repeat (3) @(negedge clk);
    send(52);
    chk_trip("R10 avg 52.25 after idle", 1'b0, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule